// File: doc/BRIEF.md
# Resonant Pole Commutation Gate Sequencer

This block drives the four gate enables of one soft-switched inverter phase leg: an upper and a lower main switch, and an upper and a lower auxiliary switch that steer a resonant branch. While the leg rests, exactly one main switch conducts. When the commanded leg level differs from the level the leg actually holds, the block starts a commutation. It takes the most recent signed leg-current sample that arrived with its valid strobe and, together with the direction of travel, uses it to address a constant table of delays. That table entry also loads a mode register, which decides whether the resonant branch assists the transition.

After a fixed setup latency, the block loads three down-counting timers and starts them in the same cycle. The expiries of those timers move the gates through the assisted or unassisted path for the given direction. Once a commutation has begun it always runs to the end. Command changes that arrive meanwhile are not queued. When the sequence finishes, the block compares the command with the new leg level again and, if they differ, starts the next commutation at once.

All timing parameters are counted in ticks of TICK_DIV clock cycles. At the default 100 MHz clock one tick is 0.1 µs. The current code has a weight of 0.25 A per LSB, so the default threshold code of 40 corresponds to 10 A.

Top module: `rpc_gate_sequencer`

## Requirements
- R1: In reset, and whenever the block is idle, the lower main enable equals the inverse of the leg level, the upper main enable equals the leg level, and both auxiliary enables are low. Reset leaves the leg low, so gate_dn is 1 and gate_up, aux_up, aux_dn and busy are 0.
- R2: A commutation starts on the first clock edge at which the block is idle and cmd_level differs from the leg level. busy is high from the next cycle. The current used is the last isense value presented with isense_vld high before that edge, and isense without the strobe is ignored.
- R3: The current code is two's complement at 0.25 A per LSB, with threshold code THRESH_CODE = 40 (10 A). A rising transition (low to high) is assisted when code > -40. A falling transition is assisted when code < 40. Otherwise it is unassisted and no auxiliary enable rises.
- R4: For an assisted rising transition, aux_dn turns on at sequence start, gate_dn turns off at event 1, gate_up turns on at event 2, and aux_dn turns off at event 3, which ends the sequence.
- R5: For an unassisted rising transition, gate_dn turns off at sequence start and gate_up turns on at event 2, which ends the sequence.
- R6: Falling transitions mirror R4 and R5. aux_up replaces aux_dn, and the roles of gate_up and gate_dn swap.
- R7: Sequence start falls exactly SETUP_TICKS*TICK_DIV cycles (600 cycles, 6 µs) after the starting edge. No gate changes during setup.
- R8: With f = code for rising and f = -code for falling, and b = f/4 when f > 0 and 0 otherwise, the delays in ticks are as follows. Assisted: T1 = 8+b, T2 = T1+6, T3 = T2+8+b. Unassisted: T2 = 3+(128+f)/8. Event k takes effect Tk*TICK_DIV+1 cycles after sequence start, so busy stays high for 600+Tend*10+1 cycles.
- R9: While busy, cmd_level changes do not alter the running sequence. At completion the block returns to idle for one cycle. It starts a new sequence on the next edge only if cmd_level differs from the new leg level.
- R10: gate_up and gate_dn are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_level | input | 1 | Commanded leg level (1 = high rail) |
| isense | input | 8 | Signed leg-current sample, 0.25 A per LSB |
| isense_vld | input | 1 | Strobe qualifying isense |
| gate_up | output | 1 | Upper main switch enable |
| gate_dn | output | 1 | Lower main switch enable |
| aux_up | output | 1 | Upper auxiliary switch enable |
| aux_dn | output | 1 | Lower auxiliary switch enable |
| busy | output | 1 | Commutation in progress |

## Verification
A wrong mode register or direction bit shows up at the first gate change after setup: the wrong auxiliary enable rises, or a main switch drops when it should not, exactly 600 cycles after the start edge. A wrong table entry or timer count moves one gate edge by at least one tick (10 cycles), and the per-cycle comparison against a behavioural model catches that in the cycle it happens. A fault in the re-arm logic shows as busy staying low after completion despite a pending command difference, or as a restart that should not occur, visible one cycle after busy falls.

// File: rtl/rpc_pkg.sv
// Package: shared types and the delay-table builder for the gate sequencer.
// Assumes delays are whole timer ticks and fit in DLY_W bits.
package rpc_pkg;

    localparam int DLY_W = 16;

    // Delay-law constants, all in ticks
    localparam int BOOST_BASE = 8;
    localparam int RISE_GAP   = 6;
    localparam int DECAY_BASE = 8;
    localparam int FREE_BASE  = 3;
    localparam int FREE_DIV   = 8;
    localparam int BOOST_DIV  = 4;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_RUN   = 2'd2
    } rpc_phase_t;

    typedef struct packed {
        logic             assist;
        logic [DLY_W-1:0] t_a;
        logic [DLY_W-1:0] t_b;
        logic [DLY_W-1:0] t_c;
    } rpc_entry_t;

    // Computes one table row from a signed current code and a direction
    function automatic rpc_entry_t rpc_calc(input int code, input logic rising,
                                            input int thresh, input int cur_w);
        rpc_entry_t e;
        int fwd;
        int boost;
        int a;
        int b;
        int c;
        fwd   = rising ? code : -code;
        boost = (fwd > 0) ? (fwd / BOOST_DIV) : 0;
        e.assist = (fwd > -thresh);
        if (e.assist) begin
            a = BOOST_BASE + boost;
            b = a + RISE_GAP;
            c = b + DECAY_BASE + boost;
        end else begin
            a = 0;
            b = FREE_BASE + (((1 << (cur_w - 1)) + fwd) / FREE_DIV);
            c = 0;
        end
        e.t_a = DLY_W'(a);
        e.t_b = DLY_W'(b);
        e.t_c = DLY_W'(c);
        return e;
    endfunction

endpackage

// File: rtl/rpc_sample_hold.sv
// Holds the latest strobed current sample.
// Assumes the sample source presents a code and a one-cycle valid.
module rpc_sample_hold #(
    parameter int CUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CUR_W-1:0] smp_in,
    input  logic             smp_vld,
    output logic [CUR_W-1:0] smp_held
);

    logic [CUR_W-1:0] held_q;

    // Capture the sample only when it is qualified
    always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= '0;
        else if (smp_vld) held_q <= smp_in;
    end

    assign smp_held = held_q;

endmodule

// File: rtl/rpc_delay_rom.sv
// Constant delay table, one row per current code and direction.
// Rows are computed at elaboration; the address is {rising, code}.
module rpc_delay_rom
    import rpc_pkg::*;
#(
    parameter int CUR_W  = 8,
    parameter int THRESH = 40
) (
    input  logic             rising,
    input  logic [CUR_W-1:0] code,
    output rpc_entry_t       entry
);

    localparam int CODES = 1 << CUR_W;
    localparam int ROWS  = 2 * CODES;

    rpc_entry_t tbl [ROWS];

    // Build every row from the delay law
    for (genvar g = 0; g < ROWS; g++) begin : g_row
        localparam int RAW  = g % CODES;
        localparam int SVAL = (RAW >= CODES / 2) ? (RAW - CODES) : RAW;
        assign tbl[g] = rpc_calc(SVAL, (g >= CODES), THRESH, CUR_W);
    end

    assign entry = tbl[{rising, code}];

endmodule

// File: rtl/rpc_timer.sv
// Down-counting timer with a tick prescaler.
// Loading also starts it; expired holds until clear or the next load.
module rpc_timer #(
    parameter int DLY_W    = 16,
    parameter int TICK_DIV = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [DLY_W-1:0] value,
    output logic             expired
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DLY_W-1:0] count_q;
    logic [PRE_W-1:0] pre_q;
    logic             armed_q;

    // Load, then count down one step per prescaled tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            pre_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            count_q <= value;
            pre_q   <= '0;
            armed_q <= 1'b1;
        end else if (clear) begin
            armed_q <= 1'b0;
        end else if (armed_q && count_q != '0) begin
            if (pre_q == PRE_W'(TICK_DIV - 1)) begin
                pre_q   <= '0;
                count_q <= count_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = armed_q && (count_q == '0);

    // Counting never goes up while armed without a new load (R8)
    assert_count_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !load && !clear) |=> (count_q <= $past(count_q)));

endmodule

// File: rtl/rpc_gate_sequencer.sv
// Gate sequencer for one resonant-pole inverter leg.
// Starts when the command differs from the leg level and waits a fixed setup.
// Then runs a timed assisted or unassisted path picked by the table mode bit.
// Assumes the table guarantees T1 < T2 < T3 for assisted rows.
module rpc_gate_sequencer
    import rpc_pkg::*;
#(
    parameter int CUR_W       = 8,
    parameter int TICK_DIV    = 10,
    parameter int SETUP_TICKS = 60,
    parameter int THRESH_CODE = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_level,
    input  logic [CUR_W-1:0] isense,
    input  logic             isense_vld,
    output logic             gate_up,
    output logic             gate_dn,
    output logic             aux_up,
    output logic             aux_dn,
    output logic             busy
);

    localparam int SETUP_CYC = SETUP_TICKS * TICK_DIV;
    localparam int SCNT_W    = $clog2(SETUP_CYC + 1);
    localparam int NTMR      = 3;

    rpc_phase_t       phase_q;
    logic [SCNT_W-1:0] scnt_q;
    logic             dir_q;
    logic             leg_q;
    logic             assist_q;
    logic             off_done_q;
    logic             on_done_q;
    logic [CUR_W-1:0] code_q;
    logic [CUR_W-1:0] held;
    rpc_entry_t       entry;
    logic [DLY_W-1:0] tval [NTMR];
    logic [NTMR-1:0]  tmr_exp;
    logic             setup_end;
    logic             seq_done;
    logic             gate_up_q, gate_dn_q, aux_up_q, aux_dn_q;

    rpc_sample_hold #(.CUR_W(CUR_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (isense),
        .smp_vld  (isense_vld),
        .smp_held (held)
    );

    rpc_delay_rom #(.CUR_W(CUR_W), .THRESH(THRESH_CODE)) u_rom (
        .rising (dir_q),
        .code   (code_q),
        .entry  (entry)
    );

    assign tval[0] = entry.t_a;
    assign tval[1] = entry.t_b;
    assign tval[2] = entry.t_c;

    assign setup_end = (phase_q == PH_SETUP) && (scnt_q == SCNT_W'(SETUP_CYC - 1));
    assign seq_done  = (phase_q == PH_RUN) && (assist_q ? tmr_exp[2] : tmr_exp[1]);

    // Three timers loaded and started in the same cycle
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        rpc_timer #(.DLY_W(DLY_W), .TICK_DIV(TICK_DIV)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (setup_end),
            .clear   (seq_done),
            .value   (tval[g]),
            .expired (tmr_exp[g])
        );
    end

    // Phase control, mode register and leg level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            scnt_q     <= '0;
            dir_q      <= 1'b0;
            leg_q      <= 1'b0;
            assist_q   <= 1'b0;
            off_done_q <= 1'b0;
            on_done_q  <= 1'b0;
            code_q     <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (cmd_level != leg_q) begin
                        phase_q <= PH_SETUP;
                        scnt_q  <= '0;
                        dir_q   <= cmd_level;
                        code_q  <= held;
                    end
                end
                PH_SETUP: begin
                    if (setup_end) begin
                        phase_q    <= PH_RUN;
                        assist_q   <= entry.assist;
                        off_done_q <= 1'b0;
                        on_done_q  <= 1'b0;
                    end else begin
                        scnt_q <= scnt_q + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (assist_q && tmr_exp[0]) off_done_q <= 1'b1;
                    if (tmr_exp[1])             on_done_q  <= 1'b1;
                    if (seq_done) begin
                        phase_q <= PH_IDLE;
                        leg_q   <= dir_q;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Gate enables driven by sequence start and timer expiries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_up_q <= 1'b0;
            gate_dn_q <= 1'b1;
            aux_up_q  <= 1'b0;
            aux_dn_q  <= 1'b0;
        end else if (setup_end) begin
            if (entry.assist) begin
                if (dir_q) aux_dn_q <= 1'b1;
                else       aux_up_q <= 1'b1;
            end else begin
                if (dir_q) gate_dn_q <= 1'b0;
                else       gate_up_q <= 1'b0;
            end
        end else if (phase_q == PH_RUN) begin
            if (assist_q && tmr_exp[0] && !off_done_q) begin
                if (dir_q) gate_dn_q <= 1'b0;
                else       gate_up_q <= 1'b0;
            end
            if (tmr_exp[1] && !on_done_q) begin
                if (dir_q) gate_up_q <= 1'b1;
                else       gate_dn_q <= 1'b1;
            end
            if (assist_q && tmr_exp[2]) begin
                aux_up_q <= 1'b0;
                aux_dn_q <= 1'b0;
            end
        end
    end

    assign gate_up = gate_up_q;
    assign gate_dn = gate_dn_q;
    assign aux_up  = aux_up_q;
    assign aux_dn  = aux_dn_q;
    assign busy    = (phase_q != PH_IDLE);

    // Main switches never conduct together (R10)
    assert_no_shoot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_up_q && gate_dn_q));

    // Idle leg shows its level on the mains with the branch off (R1)
    assert_idle_leg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> (gate_up_q == leg_q && gate_dn_q == !leg_q
                                  && !aux_up_q && !aux_dn_q));

    // At most one auxiliary enable, and only inside a sequence (R3)
    assert_aux_in_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_up_q || aux_dn_q) |-> (busy && !(aux_up_q && aux_dn_q)));

    // Gates stay still during setup (R7)
    assert_setup_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SETUP) |=> $stable({gate_up_q, gate_dn_q}) || $past(setup_end));

    // Direction cannot change mid-sequence (R9)
    assert_dir_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> (phase_q == PH_IDLE) || (dir_q == $past(dir_q)));

endmodule

// File: tb/rpc_gate_sequencer_tb.sv
module rpc_gate_sequencer_tb;

    localparam int DIV       = 10;
    localparam int SETUP_CYC = 600;
    localparam int WD_CYC    = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_level = 1'b0;
    logic [7:0] isense = 8'd0;
    logic       isense_vld = 1'b0;
    logic       gate_up, gate_dn, aux_up, aux_dn, busy;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    // Reference model state
    int mph = 0, mcnt = 0, mheld = 0, mcode = 0;
    bit mleg = 0, mdir = 0, ma = 0;
    bit mup = 0, mdn = 1, maup = 0, madn = 0;
    int t1 = 0, t2 = 0, t3 = 0;

    always #5 clk = ~clk;

    rpc_gate_sequencer u_dut (
        .clk (clk), .rst_n (rst_n), .cmd_level (cmd_level),
        .isense (isense), .isense_vld (isense_vld),
        .gate_up (gate_up), .gate_dn (gate_dn),
        .aux_up (aux_up), .aux_dn (aux_dn), .busy (busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Delay law from R3/R8, in ticks
    task automatic ref_law(input int code, input bit rising,
                           output bit as, output int a, output int b, output int c);
        int f;
        int bo;
        f  = rising ? code : -code;
        as = (f > -40);
        bo = (f > 0) ? f / 4 : 0;
        if (as) begin
            a = 8 + bo; b = a + 6; c = b + 8 + bo;
        end else begin
            a = 0; b = 3 + (128 + f) / 8; c = 0;
        end
    endtask

    // Behavioural cycle model
    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0; mcnt = 0; mleg = 0; mup = 0; mdn = 1; maup = 0; madn = 0; mheld = 0;
        end else begin
            case (mph)
                0: if (cmd_level != mleg) begin
                    mph = 1; mcnt = 0; mdir = cmd_level; mcode = mheld;
                    ref_law(mcode, mdir, ma, t1, t2, t3);
                end
                1: begin
                    mcnt++;
                    if (mcnt == SETUP_CYC) begin
                        mph = 2; mcnt = 0;
                        if (ma) begin if (mdir) madn = 1; else maup = 1; end
                        else begin if (mdir) mdn = 0; else mup = 0; end
                    end
                end
                default: begin
                    mcnt++;
                    if (ma && mcnt == t1 * DIV + 1) begin if (mdir) mdn = 0; else mup = 0; end
                    if (mcnt == t2 * DIV + 1) begin
                        if (mdir) mup = 1; else mdn = 1;
                        if (!ma) begin mph = 0; mleg = mdir; end
                    end
                    if (ma && mcnt == t3 * DIV + 1) begin
                        maup = 0; madn = 0; mph = 0; mleg = mdir;
                    end
                end
            endcase
            if (isense_vld) mheld = int'($signed(isense));
        end
    end

    // Compare against the model every cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            string tg;
            tg = (mph == 0) ? "R2" : (mph == 1) ? "R7" :
                 (!mdir) ? "R6" : (ma ? "R4" : "R5");
            chk(tg, "gate_up", gate_up, mup);
            chk(tg, "gate_dn", gate_dn, mdn);
            chk("R3", "aux_up", aux_up, maup);
            chk("R3", "aux_dn", aux_dn, madn);
            chk("R9", "busy", busy, (mph != 0));
            chk("R10", "both mains", gate_up && gate_dn, 0);
        end
    end

    // One commutation; checks its length against the delay law (R8)
    task automatic run_seq(input bit target, input int code, input bit strobe, input int exp_code);
        bit as;
        int a, b, c, n, tend;
        @(negedge clk);
        isense = 8'(code); isense_vld = strobe;
        @(negedge clk);
        isense_vld = 1'b0; cmd_level = target;
        if (!strobe) isense = 8'(code + 1);
        @(negedge clk);
        chk("R2", "busy after start", busy, 1);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        ref_law(exp_code, target, as, a, b, c);
        tend = as ? c : b;
        chk("R8", "sequence length", n, SETUP_CYC + tend * DIV + 1);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "gate_dn in reset", gate_dn, 1);
        chk("R1", "gate_up in reset", gate_up, 0);
        chk("R1", "busy in reset", busy, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "idle after reset", {gate_up, gate_dn, aux_up, aux_dn, busy}, 5'b01000);

        run_seq(1, 20, 1, 20);      // R4 assisted rising, positive current
        run_seq(0, 20, 1, 20);      // R6 assisted falling, small opposing current
        run_seq(1, -39, 1, -39);    // R3 boundary: assisted
        run_seq(0, 39, 1, 39);      // R3 boundary: assisted
        run_seq(1, -40, 1, -40);    // R5 boundary: unassisted
        run_seq(0, 40, 1, 40);      // R6 unassisted falling
        run_seq(1, -128, 1, -128);  // R5 extreme code
        run_seq(0, -128, 1, -128);  // R6 largest boost
        run_seq(1, 127, 1, 127);    // R4 largest boost
        run_seq(0, -100, 0, 127);   // R2 unstrobed sample ignored

        // R9: edges during a sequence, ending equal to the new level
        @(negedge clk);
        isense = 8'd0; isense_vld = 1'b1;
        @(negedge clk);
        isense_vld = 1'b0; cmd_level = 1'b1;
        repeat (300) @(negedge clk);
        cmd_level = 1'b0;
        repeat (100) @(negedge clk);
        cmd_level = 1'b1;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9", "no restart when command matches", busy, 0);
        chk("R9", "leg high", gate_up, 1);

        // R9: command left different at completion restarts at once
        cmd_level = 1'b0;
        repeat (200) @(negedge clk);
        cmd_level = 1'b1;
        while (busy) @(negedge clk);
        chk("R9", "one idle cycle", busy, 0);
        @(negedge clk);
        chk("R9", "immediate restart", busy, 1);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9", "leg returns high", gate_up, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule